// File: doc/BRIEF.md
# Block Lock Protection Unit

This unit guards the array of a sixteen-block flash memory against unwanted change. It holds one lock bit for each 64 KB block and a single master lock bit that can be set once and never cleared. For the operation the write engine presents, it computes at once whether the operation may go ahead. The rules weigh the target block's lock bit, the master lock and the level of the reset pin. The highest reset-pin level works as an override.

When the write engine finishes a lock-set or lock-clear operation, it pulses a commit strobe, and the unit then updates its bits. If a clear-all is cut short, the engine raises an abort strobe. In that case every block lock bit is forced to 1, so the protected state after the abort is known. The unit also answers identifier-mode reads. These return two fixed codes, each block's lock bit and the master lock bit. The system reset loads the as-shipped state, with every bit cleared. Keeping the bits across power loss is not modelled.

Top module: `blk_lock_guard`

## Requirements
- R1: For erase (op 1) or byte write (op 2), permit_o is 1 when the target block's lock bit is 0, or when rp_lvl_i is 3 (override); otherwise it is 0.
- R2: When rp_lvl_i is 0 (reset pin low), permit_o is 0 for every operation.
- R3: For set-block-lock (op 3) and clear-all-locks (op 5), permit_o is 1 when the master lock is 0, or when rp_lvl_i is 3.
- R4: Set-master-lock (op 4) is permitted only at rp_lvl_i 3. Once the master lock is 1, nothing but the system reset returns it to 0.
- R5: On a cycle with commit_i high and permit_o high, op 3 sets the lock bit of blk_i, and op 4 sets the master lock. A commit while permit_o is 0 changes no bit.
- R6: A permitted op 5 commit clears all sixteen block lock bits in one cycle. It leaves the master lock unchanged.
- R7: abort_i high with a permitted op 5, and commit_i low, sets all sixteen block lock bits to 1 on the next edge.
- R8: viol_o is 1 exactly when op_i is non-zero and permit_o is 0. set_err_o equals viol_o for ops 3 and 4. clr_err_o equals viol_o for op 5. Both error flags are 0 for all other ops.
- R9: In identifier reads, rd_addr_i 0x00000 returns 0x89 and 0x00001 returns 0xA6. Address 0xB0002 returns block B's lock bit in bit 0. Address 0x00003 returns the master lock in bit 0. All other bits, and all other addresses, return 0.
- R10: rp_lvl_i 2 (intermediate) is treated exactly like 1 (normal high).
- R11: After the system reset, all block lock bits and the master lock read 0. Op 0 (none) is never permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset; loads the as-shipped state |
| op_i | input | 3 | Requested operation: 0 none, 1 erase, 2 byte write, 3 set block lock, 4 set master lock, 5 clear all locks |
| blk_i | input | 4 | Target block index (address bits 19:16) |
| rp_lvl_i | input | 2 | Reset-pin level: 0 low, 1 high, 2 intermediate, 3 override |
| commit_i | input | 1 | Write engine finished op_i; apply it |
| abort_i | input | 1 | Write engine aborted op_i |
| rd_addr_i | input | 20 | Identifier-mode read address |
| permit_o | output | 1 | Requested operation is allowed |
| viol_o | output | 1 | Requested operation is refused (protection abort) |
| set_err_o | output | 1 | Refused lock-set request |
| clr_err_o | output | 1 | Refused lock-clear request |
| id_data_o | output | 8 | Identifier read data |

## Verification
The bench walks a sequence in which each lock change feeds the next decision. It covers a locked block reached through the override, the intermediate pin level, a set-master attempt at normal high, and the moment the master lock starts refusing block-lock changes. A design that confused levels 2 and 3 would open locked blocks. A design that applied refused commits would show a lock bit changed by a denied clear-all. The aborted clear-all is checked to read all ones, and then a later override clear is checked to bring them back to zero. This catches designs that leave the bits unchanged, or that also touch the master lock. Identifier reads at unmapped offsets, and at non-zero blocks for device-wide offsets, must return 0. A decoder that ignores the block field would fail here.

// File: rtl/blk_lock_guard.sv
module blk_lock_guard #(
  parameter int ADDR_W = 20,
  parameter int BLK_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [1:0]        rp_lvl_i,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              permit_o,
  output logic              viol_o,
  output logic              set_err_o,
  output logic              clr_err_o,
  output logic [7:0]        id_data_o
);
  localparam int NBLK  = 1 << BLK_W;
  localparam int OFF_W = ADDR_W - BLK_W;

  localparam logic [2:0] OP_NONE = 3'd0, OP_ERASE = 3'd1, OP_WRITE = 3'd2,
                         OP_SETB = 3'd3, OP_SETM = 3'd4, OP_CLR = 3'd5;

  logic [NBLK-1:0] lock_q;
  logic            master_q;

  wire pin_up = rp_lvl_i != 2'd0;
  wire pin_hv = rp_lvl_i == 2'd3;
  wire cfg_ok = pin_up && (!master_q || pin_hv);

  always_comb begin
    case (op_i)
      OP_ERASE, OP_WRITE: permit_o = pin_up && (!lock_q[blk_i] || pin_hv);
      OP_SETB, OP_CLR:    permit_o = cfg_ok;
      OP_SETM:            permit_o = pin_hv;
      default:            permit_o = 1'b0;
    endcase
  end

  assign viol_o    = (op_i != OP_NONE) && !permit_o;
  assign set_err_o = viol_o && (op_i == OP_SETB || op_i == OP_SETM);
  assign clr_err_o = viol_o && (op_i == OP_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= '0;
      master_q <= 1'b0;
    end else if (commit_i && permit_o) begin
      case (op_i)
        OP_SETB: lock_q[blk_i] <= 1'b1;
        OP_SETM: master_q      <= 1'b1;
        OP_CLR:  lock_q        <= '0;
        default: ;
      endcase
    end else if (abort_i && permit_o && op_i == OP_CLR) begin
      lock_q <= '1;
    end
  end

  wire [BLK_W-1:0] rd_blk = rd_addr_i[ADDR_W-1:OFF_W];
  wire [OFF_W-1:0] rd_off = rd_addr_i[OFF_W-1:0];

  always_comb begin
    id_data_o = 8'h00;
    if (rd_off == OFF_W'(2))
      id_data_o = {7'b0, lock_q[rd_blk]};
    else if (rd_blk == '0) begin
      if (rd_off == OFF_W'(0))      id_data_o = 8'h89;
      else if (rd_off == OFF_W'(1)) id_data_o = 8'hA6;
      else if (rd_off == OFF_W'(3)) id_data_o = {7'b0, master_q};
    end
  end

  // R2
  rp_low_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_lvl_i == 2'd0 |-> !permit_o);
  // R4
  master_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_q |=> master_q);
  // R4
  master_needs_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_q) |-> $past(rp_lvl_i) == 2'd3);
  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i && permit_o && op_i == OP_CLR |=> lock_q == '0);
  // R7
  abort_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i && !commit_i && permit_o && op_i == OP_CLR |=> lock_q == '1);
  // R5
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i && !abort_i |=> $stable(lock_q) && $stable(master_q));
  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(permit_o && viol_o) && !(set_err_o && clr_err_o));
endmodule

// File: tb/blk_lock_guard_tb.sv
module blk_lock_guard_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op = '0;
  logic [3:0] blk = '0;
  logic [1:0] lvl = 2'd1;
  logic commit = 1'b0, abort = 1'b0;
  logic [19:0] rd_addr = '0;
  logic permit, viol, set_err, clr_err;
  logic [7:0] id_data;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  blk_lock_guard dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op), .blk_i(blk), .rp_lvl_i(lvl),
    .commit_i(commit), .abort_i(abort), .rd_addr_i(rd_addr),
    .permit_o(permit), .viol_o(viol), .set_err_o(set_err),
    .clr_err_o(clr_err), .id_data_o(id_data)
  );

  // {op, blk, lvl, expected permit}; each row is committed
  localparam logic [9:0] VEC [21] = '{
    {3'd1, 4'd2,  2'd1, 1'b1},  // R1 erase unlocked
    {3'd3, 4'd2,  2'd1, 1'b1},  // R3 set lock 2
    {3'd1, 4'd2,  2'd1, 1'b0},  // R1 locked
    {3'd2, 4'd2,  2'd2, 1'b0},  // R10 intermediate
    {3'd2, 4'd2,  2'd3, 1'b1},  // R1 override
    {3'd2, 4'd3,  2'd1, 1'b1},  // R1 other block
    {3'd4, 4'd0,  2'd1, 1'b0},  // R4
    {3'd4, 4'd0,  2'd2, 1'b0},  // R4 R10
    {3'd3, 4'd9,  2'd0, 1'b0},  // R2
    {3'd3, 4'd9,  2'd1, 1'b1},  // R3 set lock 9
    {3'd5, 4'd0,  2'd1, 1'b1},  // R6 clear all
    {3'd1, 4'd9,  2'd1, 1'b1},  // R6 block 9 free
    {3'd3, 4'd15, 2'd1, 1'b1},  // R3 set lock 15
    {3'd4, 4'd0,  2'd3, 1'b1},  // R4 set master
    {3'd3, 4'd0,  2'd1, 1'b0},  // R3 master gates
    {3'd5, 4'd0,  2'd1, 1'b0},  // R3 R5 clear refused
    {3'd5, 4'd0,  2'd2, 1'b0},  // R10
    {3'd3, 4'd0,  2'd3, 1'b1},  // R3 override
    {3'd1, 4'd15, 2'd1, 1'b0},  // R5 lock 15 kept
    {3'd1, 4'd0,  2'd3, 1'b1},  // R1
    {3'd0, 4'd0,  2'd3, 1'b0}   // R11 none
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [19:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    #1 chk(req, id_data, exp);
  endtask

  task automatic flags(input string req, input logic p);
    logic v;
    v = (op != 3'd0) && !p;
    chk(req, {7'b0, permit}, {7'b0, p});
    chk({req, " R8 viol"}, {7'b0, viol}, {7'b0, v});
    chk({req, " R8 set_err"}, {7'b0, set_err}, {7'b0, v && (op == 3'd3 || op == 3'd4)});
    chk({req, " R8 clr_err"}, {7'b0, clr_err}, {7'b0, v && (op == 3'd5)});
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R11 reset state
    rd(20'h00002, 8'h00, "R11 lock0");
    rd(20'hF0002, 8'h00, "R11 lock15");
    rd(20'h00003, 8'h00, "R11 master");
    rd(20'h00000, 8'h89, "R9 code0");
    rd(20'h00001, 8'hA6, "R9 code1");

    for (int i = 0; i < 21; i++) begin
      @(negedge clk);
      {op, blk, lvl} = VEC[i][9:1];
      commit = 1'b1;
      #1 flags($sformatf("R1-row%0d", i), VEC[i][0]);
    end
    @(negedge clk) commit = 1'b0;

    rd(20'h00002, 8'h01, "R3 lock0");
    rd(20'hF0002, 8'h01, "R5 lock15 after refused clear");
    rd(20'h90002, 8'h00, "R6 lock9");
    rd(20'h20002, 8'h00, "R6 lock2");
    rd(20'h00003, 8'h01, "R4 master");
    rd(20'h00004, 8'h00, "R9 unmapped");
    rd(20'h30000, 8'h00, "R9 blk3 off0");
    rd(20'h50003, 8'h00, "R9 blk5 off3");

    // R7 aborted clear-all
    @(negedge clk);
    op = 3'd5; lvl = 2'd3; abort = 1'b1;
    @(negedge clk) abort = 1'b0; op = 3'd0;
    rd(20'h50002, 8'h01, "R7 lock5");
    rd(20'h20002, 8'h01, "R7 lock2");
    rd(20'h00003, 8'h01, "R7 master kept");

    // R6 override clear after abort
    @(negedge clk);
    op = 3'd5; lvl = 2'd3; commit = 1'b1;
    @(negedge clk) commit = 1'b0; op = 3'd0;
    rd(20'h50002, 8'h00, "R6 lock5");
    rd(20'hF0002, 8'h00, "R6 lock15");
    rd(20'h00003, 8'h01, "R4 master survives");

    // R2 rp low blocks erase of unlocked block
    @(negedge clk);
    op = 3'd1; blk = 4'd7; lvl = 2'd0;
    #1 flags("R2 erase rp low", 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule